// File: doc/BRIEF.md
# Sorted Flow-Head Scheduler

This block holds the head element of every backlogged flow in a single register array. The array is kept in ascending rank order across all logical queues that share it. Each entry carries a rank, a logical queue number, a flow number and an opaque metadata word. A pop names a logical queue and returns the lowest-ranked entry of that queue. Entries whose flow is currently paused by flow control are passed over. A surrounding queue manager uses it as the ordering engine of a push-in first-out queue. Each cycle the manager may offer a new head (a flow that has just become non-empty), a reinsert (a flow that was just served and is still backlogged) and a pop.

Every operation passes through two pipeline stages. The first stage locates positions: the insertion slot for each push, and the first eligible match for the pop. It works against the array as it will look once the operation ahead of it has been applied. The second stage removes the popped entry, then places the reinsert, then places the new head, correcting each index for the shifts made before it in the same cycle. A pop request sampled at clock edge k produces its response on the outputs for the one cycle that follows edge k+1.

Top module: `flow_head_sorter`

## Requirements
- R1: After reset the array holds no entries, `deq_valid`, `deq_empty` and `overflow` are 0, and a pop issued after reset reports empty, even if entries were held before the reset.
- R2: A pop request sampled at edge k returns, during the cycle after edge k+1, the lowest-ranked eligible entry whose queue number equals `pop_lpifo`, with `deq_valid` high for that one cycle, and removes that entry.
- R3: Entries of equal rank leave in arrival order. When a reinsert and a new head arrive in the same cycle, the reinsert counts as the earlier arrival.
- R4: Order is by rank alone, whatever the queue number. A pop of one queue leaves the relative order of every other entry unchanged, and `deq_lpifo` equals the requested queue.
- R5: A pop that finds no eligible entry for its queue raises `deq_empty`, not `deq_valid`, for one cycle at the same time a hit would have appeared, and leaves the array unchanged.
- R6: An entry whose flow bit in `flow_pause` is 1 at the pop's sampling edge is not selected. The next eligible entry of that queue is returned instead, and the paused entry becomes selectable again once its bit returns to 0.
- R7: A pop sees only entries present before its own cycle. Pushes sampled at the same edge as the pop are not candidates for that pop, although they are stored.
- R8: Operations issued on consecutive cycles, including pops of the same queue on every cycle, give the same results as if each operation were applied completely before the next.
- R9: The array holds at most ENTRIES entries, counting the slot freed by a hitting pop in the same cycle. A push that does not fit is dropped, with the reinsert kept in preference to the new head. `overflow` is 1 for one cycle, with the same timing as a pop response, for the operation cycle that dropped a push.
- R10: The flow number and the metadata word of a returned entry equal those supplied when the entry was pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | New flow head offered this cycle |
| ins_rank | input | RANK_W | Rank of the new head |
| ins_lpifo | input | LP_W | Logical queue of the new head |
| ins_flow | input | FLOW_W | Flow of the new head |
| ins_meta | input | META_W | Metadata of the new head |
| rei_valid | input | 1 | Reinsert of a served flow offered this cycle |
| rei_rank | input | RANK_W | Rank of the reinserted head |
| rei_lpifo | input | LP_W | Logical queue of the reinsert |
| rei_flow | input | FLOW_W | Flow of the reinsert |
| rei_meta | input | META_W | Metadata of the reinsert |
| pop_valid | input | 1 | Pop request this cycle |
| pop_lpifo | input | LP_W | Logical queue to pop |
| flow_pause | input | 2**FLOW_W | Per-flow pause bits, 1 hides the flow from pops |
| deq_valid | output | 1 | Pop response carries an entry |
| deq_empty | output | 1 | Pop response found no eligible entry |
| deq_rank | output | RANK_W | Rank of the returned entry |
| deq_lpifo | output | LP_W | Logical queue of the returned entry |
| deq_flow | output | FLOW_W | Flow of the returned entry |
| deq_meta | output | META_W | Metadata of the returned entry |
| overflow | output | 1 | A push was dropped because the array was full |

## Verification
A corrupted array shows up at the ports on the next pop that reaches the damaged region. An entry lost or duplicated by a wrong shift appears as a wrong flow number, a stale metadata word, or an unexpected empty response two cycles after that pop. A wrong index adjustment, when a pop and two pushes land together, breaks the ordering of equal ranks or across queues. This is seen in the order in which later pops drain the array. Stimulus therefore drains the array completely after each ordering scenario, so that no misplaced entry can stay hidden, and fills it to capacity to expose an off-by-one in the drop decision.

// File: rtl/fhs_pkg.sv
package fhs_pkg;

   // outcome of a pop as decided in the first pipeline stage
   typedef enum logic [1:0] {
      RSP_NONE = 2'd0,
      RSP_HIT  = 2'd1,
      RSP_MISS = 2'd2
   } pop_rsp_e;

endpackage

// File: rtl/fhs_rank_locator.sv
// Finds the insertion slot for a key: the first slot whose entry is
// empty or ranks strictly above the key (equal ranks stay ahead).
module fhs_rank_locator #(
   parameter int N  = 16,
   parameter int RW = 16,
   parameter int IW = 5
) (
   input  logic [N-1:0]         vld,
   input  logic [N-1:0][RW-1:0] rank,
   input  logic [RW-1:0]        key,
   output logic [IW-1:0]        idx
);

   logic [N-1:0] ahead;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         ahead[i] = vld[i] && (rank[i] <= key);
      end
   end

   // priority encode the first position where the mask drops to 0
   always_comb begin
      idx = IW'(N);
      for (int i = N - 1; i >= 0; i--) begin
         if (!ahead[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/fhs_match_locator.sv
// Finds the first entry of a logical queue whose flow is not paused.
module fhs_match_locator #(
   parameter int N  = 16,
   parameter int LW = 2,
   parameter int FW = 4,
   parameter int NF = 16,
   parameter int IW = 5
) (
   input  logic [N-1:0]         vld,
   input  logic [N-1:0][LW-1:0] lp,
   input  logic [N-1:0][FW-1:0] fl,
   input  logic [NF-1:0]        pause,
   input  logic [LW-1:0]        key,
   output logic                 hit,
   output logic [IW-1:0]        idx
);

   logic [N-1:0] elig;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         elig[i] = vld[i] && (lp[i] == key) && !pause[fl[i]];
      end
   end

   always_comb begin
      hit = |elig;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/fhs_entry_store.sv
// Register array plus second-stage update: remove, then reinsert,
// then new head, each index corrected for the shifts before it.
module fhs_entry_store #(
   parameter int N  = 16,
   parameter int EW = 56,
   parameter int RW = 16,
   parameter int IW = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pop_do,
   input  logic [IW-1:0]        pop_idx,
   input  logic                 rei_do,
   input  logic [IW-1:0]        rei_idx,
   input  logic [EW-1:0]        rei_ent,
   input  logic                 ins_do,
   input  logic [IW-1:0]        ins_idx,
   input  logic [EW-1:0]        ins_ent,
   output logic [N-1:0]         cur_vld,
   output logic [N-1:0][EW-1:0] cur_ent,
   output logic [N-1:0]         nxt_vld,
   output logic [N-1:0][EW-1:0] nxt_ent
);

   localparam logic [IW-1:0] ONE = IW'(1);

   logic [IW-1:0]        rei_q, ins_q;
   logic [N-1:0]         v1, v2;
   logic [N-1:0][EW-1:0] e1, e2;

   // index correction for operations applied earlier in the same cycle
   always_comb begin
      rei_q = rei_idx;
      if (pop_do && (pop_idx < rei_idx)) rei_q = rei_idx - ONE;
      ins_q = ins_idx;
      if (pop_do && (pop_idx < ins_idx)) ins_q = ins_q - ONE;
      if (rei_do && (rei_ent[EW-1 -: RW] <= ins_ent[EW-1 -: RW])) ins_q = ins_q + ONE;
   end

   // removal: entries behind the popped slot move up by one
   always_comb begin
      for (int i = 0; i < N - 1; i++) begin
         if (pop_do && (i >= int'(pop_idx))) begin
            e1[i] = cur_ent[i+1];
            v1[i] = cur_vld[i+1];
         end else begin
            e1[i] = cur_ent[i];
            v1[i] = cur_vld[i];
         end
      end
      e1[N-1] = pop_do ? '0 : cur_ent[N-1];
      v1[N-1] = pop_do ? 1'b0 : cur_vld[N-1];
   end

   // reinsert: entries at and behind the slot move down by one
   always_comb begin
      e2[0] = (rei_do && (rei_q == '0)) ? rei_ent : e1[0];
      v2[0] = (rei_do && (rei_q == '0)) ? 1'b1 : v1[0];
      for (int i = 1; i < N; i++) begin
         if (rei_do && (i == int'(rei_q))) begin
            e2[i] = rei_ent;
            v2[i] = 1'b1;
         end else if (rei_do && (i > int'(rei_q))) begin
            e2[i] = e1[i-1];
            v2[i] = v1[i-1];
         end else begin
            e2[i] = e1[i];
            v2[i] = v1[i];
         end
      end
   end

   // new head, placed last so it sits behind equal ranks
   always_comb begin
      nxt_ent[0] = (ins_do && (ins_q == '0)) ? ins_ent : e2[0];
      nxt_vld[0] = (ins_do && (ins_q == '0)) ? 1'b1 : v2[0];
      for (int i = 1; i < N; i++) begin
         if (ins_do && (i == int'(ins_q))) begin
            nxt_ent[i] = ins_ent;
            nxt_vld[i] = 1'b1;
         end else if (ins_do && (i > int'(ins_q))) begin
            nxt_ent[i] = e2[i-1];
            nxt_vld[i] = v2[i-1];
         end else begin
            nxt_ent[i] = e2[i];
            nxt_vld[i] = v2[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_vld <= '0;
         cur_ent <= '0;
      end else begin
         cur_vld <= nxt_vld;
         cur_ent <= nxt_ent;
      end
   end

endmodule

// File: rtl/flow_head_sorter.sv
module flow_head_sorter #(
   parameter int ENTRIES = 16,
   parameter int RANK_W  = 16,
   parameter int META_W  = 32,
   parameter int LPIFOS  = 4,
   parameter int FLOW_W  = 4,
   localparam int LP_W   = (LPIFOS > 1) ? $clog2(LPIFOS) : 1,
   localparam int NFLOWS = 1 << FLOW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_valid,
   input  logic [RANK_W-1:0] ins_rank,
   input  logic [LP_W-1:0]   ins_lpifo,
   input  logic [FLOW_W-1:0] ins_flow,
   input  logic [META_W-1:0] ins_meta,
   input  logic              rei_valid,
   input  logic [RANK_W-1:0] rei_rank,
   input  logic [LP_W-1:0]   rei_lpifo,
   input  logic [FLOW_W-1:0] rei_flow,
   input  logic [META_W-1:0] rei_meta,
   input  logic              pop_valid,
   input  logic [LP_W-1:0]   pop_lpifo,
   input  logic [NFLOWS-1:0] flow_pause,
   output logic              deq_valid,
   output logic              deq_empty,
   output logic [RANK_W-1:0] deq_rank,
   output logic [LP_W-1:0]   deq_lpifo,
   output logic [FLOW_W-1:0] deq_flow,
   output logic [META_W-1:0] deq_meta
   ,output logic             overflow
);

   import fhs_pkg::*;

   localparam int IDX_W = $clog2(ENTRIES + 1);
   localparam int ENT_W = RANK_W + LP_W + FLOW_W + META_W;
   localparam int LP_LO = FLOW_W + META_W;

   // elaboration-time parameter checks
   if (ENTRIES < 2)  begin : g_bad_entries $error("ENTRIES must be at least 2"); end
   if (RANK_W < 1)   begin : g_bad_rank    $error("RANK_W must be positive"); end
   if (META_W < 1)   begin : g_bad_meta    $error("META_W must be positive"); end
   if (LPIFOS < 1)   begin : g_bad_lpifo   $error("LPIFOS must be positive"); end
   if (FLOW_W < 1 || FLOW_W > 12) begin : g_bad_flow $error("FLOW_W out of range"); end

   logic [ENTRIES-1:0]             st_vld, nx_vld;
   logic [ENTRIES-1:0][ENT_W-1:0]  st_ent, nx_ent;
   logic [ENTRIES-1:0][RANK_W-1:0] st_rank, nx_rank;
   logic [ENTRIES-1:0][LP_W-1:0]   nx_lp;
   logic [ENTRIES-1:0][FLOW_W-1:0] nx_fl;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_fields
      assign st_rank[g] = st_ent[g][ENT_W-1 -: RANK_W];
      assign nx_rank[g] = nx_ent[g][ENT_W-1 -: RANK_W];
      assign nx_lp[g]   = nx_ent[g][LP_LO +: LP_W];
      assign nx_fl[g]   = nx_ent[g][META_W +: FLOW_W];
   end

   // ---------------- stage 1: locate against the upcoming array ----------
   logic [IDX_W-1:0] rei_loc, ins_loc, pop_loc;
   logic             pop_hit;

   fhs_rank_locator #(.N(ENTRIES), .RW(RANK_W), .IW(IDX_W)) i_rei_loc (
      .vld(nx_vld), .rank(nx_rank), .key(rei_rank), .idx(rei_loc));

   fhs_rank_locator #(.N(ENTRIES), .RW(RANK_W), .IW(IDX_W)) i_ins_loc (
      .vld(nx_vld), .rank(nx_rank), .key(ins_rank), .idx(ins_loc));

   fhs_match_locator #(.N(ENTRIES), .LW(LP_W), .FW(FLOW_W), .NF(NFLOWS), .IW(IDX_W)) i_pop_loc (
      .vld(nx_vld), .lp(nx_lp), .fl(nx_fl), .pause(flow_pause), .key(pop_lpifo),
      .hit(pop_hit), .idx(pop_loc));

   logic keep_rei, keep_ins, drop_any;

   always_comb begin
      int used;
      int room;
      used = 0;
      for (int i = 0; i < ENTRIES; i++) used += int'(nx_vld[i]);
      room     = ENTRIES - used + ((pop_valid && pop_hit) ? 1 : 0);
      keep_rei = rei_valid && (room >= 1);
      keep_ins = ins_valid && (room >= (keep_rei ? 2 : 1));
      drop_any = (rei_valid && !keep_rei) || (ins_valid && !keep_ins);
   end

   pop_rsp_e         s1_rsp;
   logic [IDX_W-1:0] s1_pop_idx, s1_rei_idx, s1_ins_idx;
   logic             s1_rei_do, s1_ins_do, s1_ovf;
   logic [ENT_W-1:0] s1_rei_ent, s1_ins_ent;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_rsp     <= RSP_NONE;
         s1_pop_idx <= '0;
         s1_rei_do  <= 1'b0;
         s1_rei_idx <= '0;
         s1_rei_ent <= '0;
         s1_ins_do  <= 1'b0;
         s1_ins_idx <= '0;
         s1_ins_ent <= '0;
         s1_ovf     <= 1'b0;
      end else begin
         s1_rsp     <= !pop_valid ? RSP_NONE : (pop_hit ? RSP_HIT : RSP_MISS);
         s1_pop_idx <= pop_loc;
         s1_rei_do  <= keep_rei;
         s1_rei_idx <= rei_loc;
         s1_rei_ent <= {rei_rank, rei_lpifo, rei_flow, rei_meta};
         s1_ins_do  <= keep_ins;
         s1_ins_idx <= ins_loc;
         s1_ins_ent <= {ins_rank, ins_lpifo, ins_flow, ins_meta};
         s1_ovf     <= drop_any;
      end
   end

   // ---------------- stage 2: shift the array --------------------------
   fhs_entry_store #(.N(ENTRIES), .EW(ENT_W), .RW(RANK_W), .IW(IDX_W)) i_store (
      .clk(clk), .rst_n(rst_n),
      .pop_do(s1_rsp == RSP_HIT), .pop_idx(s1_pop_idx),
      .rei_do(s1_rei_do), .rei_idx(s1_rei_idx), .rei_ent(s1_rei_ent),
      .ins_do(s1_ins_do), .ins_idx(s1_ins_idx), .ins_ent(s1_ins_ent),
      .cur_vld(st_vld), .cur_ent(st_ent), .nxt_vld(nx_vld), .nxt_ent(nx_ent));

   logic [ENT_W-1:0] sel_ent;

   always_comb begin
      sel_ent = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (IDX_W'(i) == s1_pop_idx) sel_ent = st_ent[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         deq_valid <= 1'b0;
         deq_empty <= 1'b0;
         deq_rank  <= '0;
         deq_lpifo <= '0;
         deq_flow  <= '0;
         deq_meta  <= '0;
         overflow  <= 1'b0;
      end else begin
         deq_valid <= (s1_rsp == RSP_HIT);
         deq_empty <= (s1_rsp == RSP_MISS);
         overflow  <= s1_ovf;
         if (s1_rsp == RSP_HIT) begin
            deq_rank  <= sel_ent[ENT_W-1 -: RANK_W];
            deq_lpifo <= sel_ent[LP_LO +: LP_W];
            deq_flow  <= sel_ent[META_W +: FLOW_W];
            deq_meta  <= sel_ent[META_W-1:0];
         end
      end
   end

endmodule

// File: rtl/fhs_checker.sv
module fhs_checker #(
   parameter int ENTRIES = 16,
   parameter int RANK_W  = 16,
   parameter int LP_W    = 2,
   parameter int FLOW_W  = 4,
   localparam int NFLOWS = 1 << FLOW_W
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           ins_valid,
   input logic                           rei_valid,
   input logic                           pop_valid,
   input logic [LP_W-1:0]                pop_lpifo,
   input logic [NFLOWS-1:0]              flow_pause,
   input logic                           deq_valid,
   input logic                           deq_empty,
   input logic [LP_W-1:0]                deq_lpifo,
   input logic [FLOW_W-1:0]              deq_flow,
   input logic                           overflow,
   input logic [ENTRIES-1:0]             ent_vld,
   input logic [ENTRIES-1:0][RANK_W-1:0] ent_rank
);

   logic [1:0]        since_rst;
   logic [NFLOWS-1:0] pause_d1, pause_d2;
   logic              warm;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rst <= '0;
         pause_d1  <= '0;
         pause_d2  <= '0;
      end else begin
         if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
         pause_d1 <= flow_pause;
         pause_d2 <= pause_d1;
      end
   end

   assign warm = (since_rst >= 2'd2);

   // R5
   rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(deq_valid && deq_empty));

   // R2
   rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && (deq_valid || deq_empty)) |-> $past(pop_valid, 2));

   // R2
   rsp_given_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(pop_valid, 2)) |-> (deq_valid || deq_empty));

   // R4
   lpifo_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && deq_valid) |-> (deq_lpifo == $past(pop_lpifo, 2)));

   // R6
   paused_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && deq_valid) |-> !pause_d2[deq_flow]);

   // R9
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && overflow) |-> ($past(ins_valid, 2) || $past(rei_valid, 2)));

   for (genvar g = 0; g < ENTRIES - 1; g++) begin : g_order
      // R4
      sorted_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ent_vld[g+1] |-> (ent_vld[g] && (ent_rank[g] <= ent_rank[g+1])));
   end

endmodule

bind flow_head_sorter fhs_checker #(
   .ENTRIES(ENTRIES), .RANK_W(RANK_W), .LP_W(LP_W), .FLOW_W(FLOW_W)
) i_fhs_chk (
   .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .rei_valid(rei_valid),
   .pop_valid(pop_valid), .pop_lpifo(pop_lpifo), .flow_pause(flow_pause),
   .deq_valid(deq_valid), .deq_empty(deq_empty), .deq_lpifo(deq_lpifo),
   .deq_flow(deq_flow), .overflow(overflow), .ent_vld(st_vld), .ent_rank(st_rank));

// File: tb/test_flow_head_sorter.sv
`timescale 1ns/1ps
module test_flow_head_sorter;

   localparam int N  = 4;
   localparam int RW = 16;
   localparam int MW = 32;
   localparam int LW = 2;
   localparam int FW = 4;
   localparam int NF = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ins_valid = 1'b0, rei_valid = 1'b0, pop_valid = 1'b0;
   logic [RW-1:0] ins_rank = '0, rei_rank = '0;
   logic [LW-1:0] ins_lpifo = '0, rei_lpifo = '0, pop_lpifo = '0;
   logic [FW-1:0] ins_flow = '0, rei_flow = '0;
   logic [MW-1:0] ins_meta = '0, rei_meta = '0;
   logic [NF-1:0] flow_pause = '0;
   logic          deq_valid, deq_empty, overflow;
   logic [RW-1:0] deq_rank;
   logic [LW-1:0] deq_lpifo;
   logic [FW-1:0] deq_flow;
   logic [MW-1:0] deq_meta;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   flow_head_sorter #(.ENTRIES(N), .RANK_W(RW), .META_W(MW), .LPIFOS(4), .FLOW_W(FW)) i_flow_head_sorter (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_rank(ins_rank), .ins_lpifo(ins_lpifo), .ins_flow(ins_flow), .ins_meta(ins_meta),
      .rei_valid(rei_valid), .rei_rank(rei_rank), .rei_lpifo(rei_lpifo), .rei_flow(rei_flow), .rei_meta(rei_meta),
      .pop_valid(pop_valid), .pop_lpifo(pop_lpifo), .flow_pause(flow_pause),
      .deq_valid(deq_valid), .deq_empty(deq_empty), .deq_rank(deq_rank), .deq_lpifo(deq_lpifo),
      .deq_flow(deq_flow), .deq_meta(deq_meta), .overflow(overflow));

   typedef struct packed {
      logic [7:0]  req;
      logic [15:0] pause;
      logic        iv; logic [15:0] ir; logic [1:0] ilp; logic [3:0] ifl;
      logic        rv; logic [15:0] rr; logic [1:0] rlp; logic [3:0] rfl;
      logic        pv; logic [1:0] plp;
      logic        edv; logic ede; logic [15:0] er; logic [3:0] ef; logic eov;
   } vec_t;

   // fields: req, pause, insert(v,rank,lp,flow), reinsert(v,rank,lp,flow), pop(v,lp), expect(dv,de,rank,flow,ovf)
   localparam vec_t VECS [20] = '{
      '{8'd5, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd0, 1'b0, 1'b1, 16'd0,  4'd0,  1'b0}, // R5 empty array
      '{8'd2, 16'h0000, 1'b1, 16'd20, 2'd0, 4'd1,  1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 2'd0, 1'b0, 1'b0, 16'd0,  4'd0,  1'b0}, // R2 fill
      '{8'd3, 16'h0000, 1'b1, 16'd10, 2'd1, 4'd2,  1'b1, 16'd20, 2'd0, 4'd3,  1'b0, 2'd0, 1'b0, 1'b0, 16'd0,  4'd0,  1'b0}, // R3 tie behind flow 1
      '{8'd3, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd0, 1'b1, 1'b0, 16'd20, 4'd1,  1'b0}, // R3 earlier first
      '{8'd3, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd0, 1'b1, 1'b0, 16'd20, 4'd3,  1'b0}, // R3 later second
      '{8'd7, 16'h0000, 1'b1, 16'd10, 2'd1, 4'd4,  1'b1, 16'd10, 2'd1, 4'd5,  1'b1, 2'd1, 1'b1, 1'b0, 16'd10, 4'd2,  1'b0}, // R7 pushes hidden from pop
      '{8'd3, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd1, 1'b1, 1'b0, 16'd10, 4'd5,  1'b0}, // R3 reinsert ahead of insert
      '{8'd5, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd2, 1'b0, 1'b1, 16'd0,  4'd0,  1'b0}, // R5 no match for queue 2
      '{8'd4, 16'h0000, 1'b1, 16'd5,  2'd2, 4'd6,  1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 2'd0, 1'b0, 1'b0, 16'd0,  4'd0,  1'b0}, // R4 lower rank other queue
      '{8'd4, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd1, 1'b1, 1'b0, 16'd10, 4'd4,  1'b0}, // R4 skip other queue
      '{8'd4, 16'h0000, 1'b1, 16'd30, 2'd3, 4'd7,  1'b1, 16'd1,  2'd3, 4'd8,  1'b0, 2'd0, 1'b0, 1'b0, 16'd0,  4'd0,  1'b0}, // R4 two pushes
      '{8'd9, 16'h0000, 1'b1, 16'd2,  2'd0, 4'd9,  1'b1, 16'd3,  2'd0, 4'd10, 1'b0, 2'd0, 1'b0, 1'b0, 16'd0,  4'd0,  1'b1}, // R9 one slot, insert dropped
      '{8'd9, 16'h0000, 1'b1, 16'd4,  2'd0, 4'd11, 1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd3, 1'b1, 1'b0, 16'd1,  4'd8,  1'b0}, // R9 pop frees slot
      '{8'd9, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 16'd9,  2'd1, 4'd12, 1'b0, 2'd0, 1'b0, 1'b0, 16'd0,  4'd0,  1'b1}, // R9 full, reinsert dropped
      '{8'd6, 16'h0400, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd0, 1'b1, 1'b0, 16'd4,  4'd11, 1'b0}, // R6 flow 10 paused
      '{8'd6, 16'h0400, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd0, 1'b0, 1'b1, 16'd0,  4'd0,  1'b0}, // R6 only paused left
      '{8'd6, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd0, 1'b1, 1'b0, 16'd3,  4'd10, 1'b0}, // R6 resumed
      '{8'd2, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd2, 1'b1, 1'b0, 16'd5,  4'd6,  1'b0}, // R2 drain
      '{8'd2, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd3, 1'b1, 1'b0, 16'd30, 4'd7,  1'b0}, // R2 drain
      '{8'd5, 16'h0000, 1'b0, 16'd0,  2'd0, 4'd0,  1'b0, 16'd0,  2'd0, 4'd0,  1'b1, 2'd3, 1'b0, 1'b1, 16'd0,  4'd0,  1'b0}  // R5 drained
   };

   function automatic logic [MW-1:0] meta_of(input logic [FW-1:0] f, input logic [RW-1:0] r);
      return {8'hA5, 4'h0, f, r};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      ins_valid = 1'b0; rei_valid = 1'b0; pop_valid = 1'b0; flow_pause = '0;
   endtask

   task automatic push_ins(input logic [RW-1:0] r, input logic [LW-1:0] lp, input logic [FW-1:0] f);
      ins_valid = 1'b1; ins_rank = r; ins_lpifo = lp; ins_flow = f; ins_meta = meta_of(f, r);
   endtask

   task automatic push_rei(input logic [RW-1:0] r, input logic [LW-1:0] lp, input logic [FW-1:0] f);
      rei_valid = 1'b1; rei_rank = r; rei_lpifo = lp; rei_flow = f; rei_meta = meta_of(f, r);
   endtask

   task automatic pop(input logic [LW-1:0] lp);
      pop_valid = 1'b1; pop_lpifo = lp;
   endtask

   task automatic do_reset();
      @(negedge clk); idle(); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_all();
      do_reset();
      // R1 reset state at the ports
      chk("R1 deq_valid after reset", 64'(deq_valid), 64'd0);
      chk("R1 deq_empty after reset", 64'(deq_empty), 64'd0);
      chk("R1 overflow after reset", 64'(overflow), 64'd0);

      for (int v = 0; v < 20; v++) begin
         string tag;
         vec_t t;
         t = VECS[v];
         tag = $sformatf("R%0d vector %0d", t.req, v);
         idle();
         flow_pause = t.pause;
         if (t.iv) push_ins(t.ir, t.ilp, t.ifl);
         if (t.rv) push_rei(t.rr, t.rlp, t.rfl);
         if (t.pv) pop(t.plp);
         @(posedge clk);
         @(negedge clk); idle();
         @(posedge clk);
         @(negedge clk);
         chk({tag, " deq_valid"}, 64'(deq_valid), 64'(t.edv));
         chk({tag, " deq_empty"}, 64'(deq_empty), 64'(t.ede));
         chk({tag, " overflow"}, 64'(overflow), 64'(t.eov));
         if (t.edv) begin
            chk({tag, " rank"}, 64'(deq_rank), 64'(t.er));
            chk({tag, " flow"}, 64'(deq_flow), 64'(t.ef));
            chk({tag, " lpifo"}, 64'(deq_lpifo), 64'(t.plp));
            chk({tag, " R10 meta"}, 64'(deq_meta), 64'(meta_of(t.ef, t.er)));
         end
      end

      // R8 back-to-back: two inserts then three pops of queue 1 on consecutive cycles
      @(negedge clk); idle(); push_ins(16'd7, 2'd1, 4'd1);
      @(negedge clk); idle(); push_ins(16'd3, 2'd1, 4'd2);
      @(negedge clk); idle(); pop(2'd1);
      @(negedge clk); pop(2'd1);
      @(negedge clk);
      chk("R8 first pop valid", 64'(deq_valid), 64'd1);
      chk("R8 first pop flow", 64'(deq_flow), 64'd2);
      chk("R8 first pop rank", 64'(deq_rank), 64'd3);
      pop(2'd1);
      @(negedge clk); idle();
      chk("R8 second pop valid", 64'(deq_valid), 64'd1);
      chk("R8 second pop flow", 64'(deq_flow), 64'd1);
      chk("R8 second pop rank", 64'(deq_rank), 64'd7);
      @(negedge clk);
      chk("R8 third pop empty", 64'(deq_empty), 64'd1);
      chk("R8 third pop not valid", 64'(deq_valid), 64'd0);

      // R1 reset discards held entries
      @(negedge clk); push_ins(16'd12, 2'd2, 4'd3);
      @(negedge clk); idle();
      @(negedge clk);
      do_reset();
      pop(2'd2);
      @(negedge clk); idle();
      @(negedge clk);
      chk("R1 pop after reset empty", 64'(deq_empty), 64'd1);
      chk("R1 pop after reset not valid", 64'(deq_valid), 64'd0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule